// File: doc/BRIEF.md
# I2C Byte Shift Engine with Acknowledge-Clock Control

This block moves one byte across an open-drain I2C bus per command. As a master it makes the SCL waveform from the system clock. As a slave it follows the SCL edges that another device makes. In both roles it shifts data most significant bit first. It can add a ninth clock on which the receiving side acknowledges. The sending side releases SDA during that clock and records the level it sees.

An 8-bit control word sets the SCL rate code, the standard or fast timing, the acknowledge level that this device drives as a receiver, and whether the ninth clock exists. A separate 7-bit own-address register is compared with the upper seven bits of a received address byte. When the acknowledge level is set to drive low, a match makes the block acknowledge and a mismatch makes it stay silent. Any change to the control word during a byte, other than to the acknowledge level, stops the byte and frees the bus lines.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, both line drivers are released, `busy`, `byte_done` and `addr_match` are 0, `rx_byte` is 0 and `ack_seen` is 1.
- R2: As master, each SCL high (and low) phase lasts H system clocks. H is 4·max(c,1) when control bit 5 is 0 and 2·max(c,1) when bit 5 is 1, where c is control bits 4:0.
- R3: When transmitting, bit 7 of `tx_byte` appears on SDA first. The block changes its SDA drive only while SCL reads low.
- R4: When receiving, SDA is sampled on each SCL rising edge, MSB first, and the assembled byte appears on `rx_byte` when the byte completes.
- R5: As receiver of a non-address byte, the block pulls SDA low during the ninth clock when control bit 6 is 0 and leaves SDA released when it is 1.
- R6: For a received address byte (`cmd_addr`=1), bits 7:1 are compared with the own address (written with `reg_sel`=1, data bits 6:0). The result is shown on `addr_match`. SDA is pulled low on the ninth clock only if the address matches and control bit 6 is 0.
- R7: Control bit 7 at 1 gives nine SCL clocks per byte. At 0 it gives eight.
- R8: As sender, the block releases SDA during the ninth clock and latches the sampled SDA level into `ack_seen` (0 means acknowledged).
- R9: Each completed byte raises `byte_done` for exactly one cycle.
- R10: A control write during a byte that changes any bit other than bit 6 ends the byte at once. `busy` falls, SCL is released and no `byte_done` follows. A write that changes only bit 6 lets the byte finish.
- R11: `cmd_start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control word, 1 selects own address |
| reg_wdata | input | 8 | Register write data |
| cmd_start | input | 1 | Starts one byte |
| cmd_master | input | 1 | 1 makes SCL, 0 follows SCL |
| cmd_tx | input | 1 | 1 sends `tx_byte`, 0 receives |
| cmd_addr | input | 1 | Received byte is an address byte |
| tx_byte | input | 8 | Byte to send |
| scl_in | input | 1 | Sensed SCL level |
| scl_low_o | output | 1 | Pull SCL low when 1 |
| sda_in | input | 1 | Sensed SDA level |
| sda_low_o | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Byte in progress |
| byte_done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Last byte shifted in |
| ack_seen | output | 1 | SDA level sampled on the ninth clock |
| addr_match | output | 1 | Result of the last address compare |

## Verification
The assertions assume a slave byte is started only while SCL is held low by the far side. They also assume the far side changes SDA only while SCL is low, so every SCL edge the block sees belongs to the current byte. The bench's bus model pulls SCL low before each slave command and updates its SDA drive only on clock phases where SCL reads low. Random choices are limited to rate codes that keep each byte short; the slowest rate is reached only in a directed case.

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic       cmd_start,
  input  logic       cmd_master,
  input  logic       cmd_tx,
  input  logic       cmd_addr,
  input  logic [7:0] tx_byte,
  input  logic       scl_in,
  output logic       scl_low_o,
  input  logic       sda_in,
  output logic       sda_low_o,
  output logic       busy,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       ack_seen,
  output logic       addr_match
);
  localparam int DIV_W = 8;

  logic [7:0]       ctl;
  logic [6:0]       own;
  logic             master, tx, is_addr, phase, scl_prev;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [DIV_W-1:0] divcnt, half;
  logic [4:0]       code_nz;
  logic             ctl_hit, abort, start, tick, rise_ev, fall_ev, last_bit, ack_drive, sda_want;

  assign code_nz   = (ctl[4:0] == 5'd0) ? 5'd1 : ctl[4:0];
  assign half      = ctl[5] ? {2'b00, code_nz, 1'b0} : {1'b0, code_nz, 2'b00};
  assign ctl_hit   = reg_we && !reg_sel;
  assign abort     = ctl_hit && busy && (((reg_wdata ^ ctl) & 8'hBF) != 8'h00);
  assign start     = cmd_start && !busy;
  assign tick      = (divcnt == '0);
  assign rise_ev   = busy && !phase && (master ? tick : (scl_in && !scl_prev));
  assign fall_ev   = busy &&  phase && (master ? tick : (!scl_in && scl_prev));
  assign last_bit  = ctl[7] ? (bitcnt == 4'd8) : (bitcnt == 4'd7);
  assign ack_drive = !ctl[6] && (!is_addr || addr_match);
  assign sda_want  = (bitcnt == 4'd8) ? (!tx && ack_drive) : (tx && !shreg[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; own <= '0; master <= 1'b0; tx <= 1'b0; is_addr <= 1'b0;
      phase <= 1'b0; scl_prev <= 1'b1; bitcnt <= '0; shreg <= '0; divcnt <= '0;
      scl_low_o <= 1'b0; sda_low_o <= 1'b0; busy <= 1'b0; byte_done <= 1'b0;
      rx_byte <= '0; ack_seen <= 1'b1; addr_match <= 1'b0;
    end else begin
      scl_prev  <= scl_in;
      byte_done <= 1'b0;
      if (reg_we && reg_sel) own <= reg_wdata[6:0];
      if (ctl_hit) ctl <= reg_wdata;
      if (!scl_in) sda_low_o <= busy ? sda_want : 1'b0;
      if (abort) begin
        busy <= 1'b0; phase <= 1'b0; scl_low_o <= 1'b0; sda_low_o <= 1'b0; divcnt <= '0;
      end else if (start) begin
        busy <= 1'b1; master <= cmd_master; tx <= cmd_tx; is_addr <= cmd_addr;
        shreg <= tx_byte; bitcnt <= '0; phase <= 1'b0;
        divcnt <= half - 8'd1; scl_low_o <= cmd_master;
      end else if (busy) begin
        if (master && !tick) divcnt <= divcnt - 8'd1;
        if (rise_ev) begin
          phase <= 1'b1;
          if (master) begin scl_low_o <= 1'b0; divcnt <= half - 8'd1; end
          if (bitcnt == 4'd8) ack_seen <= sda_in;
          else shreg <= {shreg[6:0], sda_in};
        end
        if (fall_ev) begin
          phase <= 1'b0;
          if (master) begin scl_low_o <= 1'b1; divcnt <= half - 8'd1; end
          if (is_addr && bitcnt == 4'd7) addr_match <= (shreg[7:1] == own);
          if (last_bit) begin
            busy <= 1'b0; byte_done <= 1'b1; rx_byte <= shreg;
          end else bitcnt <= bitcnt + 4'd1;
        end
      end
    end
  end

  AST_SDA_CHANGES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_low_o != $past(sda_low_o)) |-> (!$past(scl_in) || $past(abort))); // R3
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && master) |-> (divcnt < half)); // R2
  AST_BIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bitcnt <= (ctl[7] ? 4'd8 : 4'd7))); // R7
  AST_SENDER_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx && bitcnt == 4'd8 && phase) |-> !sda_low_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done); // R9
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !scl_low_o && !byte_done)); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_start && !abort) |=> ($stable(master) && $stable(tx))); // R11
endmodule

// File: tb/test_i2c_byte_engine.sv
module test_i2c_byte_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic reg_we = 0, reg_sel = 0, cmd_start = 0, cmd_master = 0, cmd_tx = 0, cmd_addr = 0;
  logic [7:0] reg_wdata = 0, tx_byte = 0;
  logic bfm_scl_low = 0, bfm_sda_low = 0;
  logic scl_low_o, sda_low_o, busy, byte_done, ack_seen, addr_match;
  logic [7:0] rx_byte;
  wire scl_in = !(scl_low_o || bfm_scl_low);
  wire sda_in = !(sda_low_o || bfm_sda_low);
  int checks = 0, fails = 0, done_cnt = 0;

  i2c_byte_engine i_i2c_byte_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cmd_start(cmd_start), .cmd_master(cmd_master), .cmd_tx(cmd_tx), .cmd_addr(cmd_addr),
    .tx_byte(tx_byte), .scl_in(scl_in), .scl_low_o(scl_low_o), .sda_in(sda_in),
    .sda_low_o(sda_low_o), .busy(busy), .byte_done(byte_done), .rx_byte(rx_byte),
    .ack_seen(ack_seen), .addr_match(addr_match));

  always @(negedge clk) if (byte_done) done_cnt++;

  function automatic int exp_half(input int code, input bit fast);
    int c = (code == 0) ? 1 : code;
    return fast ? 2 * c : 4 * c;
  endfunction

  function automatic bit exp_ack_low(input bit ack_lvl, input bit is_addr, input bit match);
    return !ack_lvl && (!is_addr || match);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic write_reg(input bit sel, input logic [7:0] d);
    @(negedge clk) begin reg_we = 1; reg_sel = sel; reg_wdata = d; end
    @(negedge clk) reg_we = 0;
  endtask

  task automatic start_cmd(input bit m, input bit t, input bit a, input logic [7:0] d);
    @(negedge clk) begin cmd_start = 1; cmd_master = m; cmd_tx = t; cmd_addr = a; tx_byte = d; end
    @(negedge clk) cmd_start = 0;
  endtask

  task automatic master_xfer(input bit t, input logic [7:0] d, input bit far_low,
                             output logic [7:0] seen, output int rises, output int hi_len,
                             output bit ackbus, output bit glitch);
    int d0 = done_cnt;
    int hic = 0;
    bit prev_scl, prev_sda, cur;
    seen = 0; rises = 0; hi_len = 0; ackbus = 1; glitch = 0;
    bfm_scl_low = 0; bfm_sda_low = 0;
    start_cmd(1, t, 0, d);
    prev_scl = scl_in; prev_sda = sda_in;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      cur = scl_in;
      if (cur && !prev_scl) begin
        rises++;
        if (rises <= 8) seen = {seen[6:0], sda_in}; else ackbus = sda_in;
        hic = 0;
      end
      if (cur) hic++;
      if (!cur && prev_scl) hi_len = hic;
      if (cur && prev_scl && sda_in != prev_sda) glitch = 1;
      if (!cur) bfm_sda_low = (rises < 8) ? (!t && !d[7-rises]) : (t && far_low);
      prev_scl = cur; prev_sda = sda_in;
      if (done_cnt != d0) break;
    end
    repeat (2) @(negedge clk);
    bfm_sda_low = 0;
  endtask

  task automatic slave_xfer(input bit t, input bit a, input logic [7:0] d, input int nclk,
                            input bit far_low, output logic [7:0] seen, output bit ackbus,
                            output bit glitch);
    bit s1;
    seen = 0; ackbus = 1; glitch = 0;
    bfm_scl_low = 1; bfm_sda_low = 0;
    @(negedge clk);
    start_cmd(0, t, a, d);
    for (int b = 0; b < nclk; b++) begin
      @(negedge clk) bfm_sda_low = (b < 8) ? (!t && !d[7-b]) : (t && far_low);
      repeat (3) @(negedge clk);
      bfm_scl_low = 0;
      repeat (2) @(negedge clk);
      s1 = sda_in;
      if (b < 8) seen = {seen[6:0], sda_in}; else ackbus = sda_in;
      repeat (2) @(negedge clk);
      if (sda_in != s1) glitch = 1;
      bfm_scl_low = 1;
    end
    @(negedge clk) bfm_sda_low = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    logic [7:0] seen;
    int rises, hl, d0;
    bit ab, gl;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_low_o && !sda_low_o, "R1 lines released", {scl_low_o, sda_low_o}, 0);
    chk(!busy && !byte_done && !addr_match, "R1 flags", {busy, byte_done, addr_match}, 0);
    chk(rx_byte == 0 && ack_seen == 1, "R1 status", {rx_byte, ack_seen}, 1);

    // R2 R3 R7 R8 R9: master send, code 0, nine clocks, far side acknowledges
    write_reg(0, 8'h80);
    d0 = done_cnt;
    master_xfer(1, 8'hA5, 1, seen, rises, hl, ab, gl);
    chk(seen == 8'hA5, "R3 msb first", seen, 8'hA5);
    chk(!gl, "R3 sda stable while scl high", gl, 0);
    chk(hl == exp_half(0, 0), "R2 code0 half", hl, exp_half(0, 0));
    chk(rises == 9, "R7 nine clocks", rises, 9);
    chk(ack_seen == 0, "R8 ack sampled", ack_seen, 0);
    chk(done_cnt == d0 + 1, "R9 one done pulse", done_cnt - d0, 1);

    // R7 R2: no ack clock, code 3 standard
    write_reg(0, 8'h03);
    master_xfer(1, 8'h3C, 0, seen, rises, hl, ab, gl);
    chk(rises == 8, "R7 eight clocks", rises, 8);
    chk(hl == exp_half(3, 0), "R2 standard half", hl, exp_half(3, 0));

    // R2 R8: fast mode, far side silent
    write_reg(0, 8'hA5);
    master_xfer(1, 8'h81, 0, seen, rises, hl, ab, gl);
    chk(hl == exp_half(5, 1), "R2 fast half", hl, exp_half(5, 1));
    chk(ack_seen == 1, "R8 no ack seen", ack_seen, 1);
    // R2 slowest directed
    write_reg(0, 8'h1F);
    master_xfer(1, 8'h55, 0, seen, rises, hl, ab, gl);
    chk(hl == exp_half(31, 0), "R2 slowest half", hl, exp_half(31, 0));

    // R4 R5: master receive, ack level 0 then 1
    write_reg(0, 8'h81);
    master_xfer(0, 8'h6E, 0, seen, rises, hl, ab, gl);
    chk(rx_byte == 8'h6E, "R4 master receive", rx_byte, 8'h6E);
    chk(ab == 0, "R5 ack driven low", ab, 0);
    write_reg(0, 8'hC1);
    master_xfer(0, 8'h93, 0, seen, rises, hl, ab, gl);
    chk(rx_byte == 8'h93, "R4 master receive 2", rx_byte, 8'h93);
    chk(ab == 1, "R5 ack released", ab, 1);

    // R11: start during busy ignored
    write_reg(0, 8'h82);
    fork
      master_xfer(1, 8'h5A, 0, seen, rises, hl, ab, gl);
      begin
        repeat (20) @(negedge clk);
        start_cmd(0, 0, 0, 8'hFF);
      end
    join
    chk(seen == 8'h5A && rises == 9, "R11 start ignored", seen, 8'h5A);

    // R6 slave address compare
    write_reg(1, 8'h2C);
    write_reg(0, 8'h82);
    slave_xfer(0, 1, {7'h2C, 1'b0}, 9, 0, seen, ab, gl);
    chk(ab == exp_ack_low(0, 1, 1) ? 1'b0 : 1'b1, "R6 match acks", ab, 0);
    chk(addr_match == 1, "R6 match flag", addr_match, 1);
    slave_xfer(0, 1, {7'h2D, 1'b1}, 9, 0, seen, ab, gl);
    chk(ab == 1, "R6 mismatch silent", ab, 1);
    chk(addr_match == 0, "R6 mismatch flag", addr_match, 0);
    write_reg(0, 8'hC2);
    slave_xfer(0, 1, {7'h2C, 1'b1}, 9, 0, seen, ab, gl);
    chk(ab == 1, "R6 ack level 1 overrides", ab, 1);

    // R5 R4 slave data receive
    write_reg(0, 8'h82);
    slave_xfer(0, 0, 8'hB7, 9, 0, seen, ab, gl);
    chk(rx_byte == 8'hB7, "R4 slave receive", rx_byte, 8'hB7);
    chk(ab == 0, "R5 slave ack low", ab, 0);

    // R3 R8 slave send
    slave_xfer(1, 0, 8'hC9, 9, 1, seen, ab, gl);
    chk(seen == 8'hC9, "R3 slave send", seen, 8'hC9);
    chk(!gl, "R3 slave sda stable", gl, 0);
    chk(ack_seen == 0, "R8 slave ack sampled", ack_seen, 0);

    // R10 abort behaviour
    bfm_scl_low = 0; bfm_sda_low = 0;
    write_reg(0, 8'h88);
    d0 = done_cnt;
    start_cmd(1, 1, 0, 8'hF0);
    repeat (30) @(negedge clk);
    write_reg(0, 8'hC8);
    chk(busy == 1, "R10 ack-only write keeps byte", busy, 1);
    for (int k = 0; k < 2000 && done_cnt == d0; k++) @(negedge clk);
    chk(done_cnt == d0 + 1, "R10 byte finishes", done_cnt - d0, 1);
    d0 = done_cnt;
    start_cmd(1, 1, 0, 8'h0F);
    repeat (30) @(negedge clk);
    write_reg(0, 8'hC9);
    chk(!busy && !scl_low_o, "R10 abort releases", {busy, scl_low_o}, 0);
    repeat (200) @(negedge clk);
    chk(done_cnt == d0, "R10 no done after abort", done_cnt - d0, 0);

    // Random master traffic
    for (int n = 0; n < 30; n++) begin
      int code = $urandom % 4;
      bit fast = $urandom % 2, ackl = $urandom % 2, ackc = $urandom % 2;
      bit t = $urandom % 2, far = $urandom % 2;
      logic [7:0] d = 8'($urandom);
      write_reg(0, {ackc, ackl, fast, 5'(code)});
      master_xfer(t, d, far, seen, rises, hl, ab, gl);
      chk(rises == (ackc ? 9 : 8), "R7 random clocks", rises, ackc ? 9 : 8);
      chk(hl == exp_half(code, fast), "R2 random half", hl, exp_half(code, fast));
      chk(!gl, "R3 random sda stable", gl, 0);
      if (t) chk(seen == d, "R3 random send", seen, d);
      else chk(rx_byte == d, "R4 random receive", rx_byte, d);
      if (ackc && t) chk(ack_seen == !far, "R8 random ack", ack_seen, !far);
      if (ackc && !t) chk(ab == !exp_ack_low(ackl, 0, 0), "R5 random ack", ab, !exp_ack_low(ackl, 0, 0));
    end
    summary();
  end
endmodule